// File: doc/BRIEF.md
# Interline CCD Readout Clock Sequencer

This block produces the logic-level phase controls that external level shifters turn into the vertical and horizontal clocks of an interline CCD with two horizontal shift registers, A and B. When a frame is requested it moves photodiode charge into the vertical registers once. It then moves rows one at a time into the horizontal registers and shifts every pixel position out. In single-register mode each row is read on its own through register A. In dual-register mode one row is loaded into A and handed to B, and a second row is loaded into A, so that both registers shift out together.

Two further options are fixed for the length of a frame. Two-to-one binning merges two rows into a register before it is read. Fast dump discards a programmable number of rows at the top of the frame by raising a dump gate while each of those rows is transferred. All pulse widths and delays are run-time inputs counted in system clock cycles. Row count and pixel count per row are parameters.

The block has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status level. A frame starts on a one-cycle request, and the block reports busy, a row counter, a pixel counter, a retrace window flag and a one-cycle end-of-frame pulse.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset and while idle: `v1_lvl`=1 (mid), `v2`=0, `h1a`=1, `h1b`=0, `h2`=0, `dump_gate`=0, `busy`=0, `frame_done`=0. Level codes on `v1_lvl` are 0 low, 1 mid, 2 high, and 3 never appears.
- R2: A `frame_start` sampled high while idle starts a frame on the next cycle. `v1_lvl` is 2 for exactly `t_vpulse` cycles, once per frame. It is then 1 for `t_vdelay` cycles before the first row transfer.
- R3: Every row transfer drives `v2`=1 with `v1_lvl`=0 for `t_vpulse` cycles, then `v2`=0 with `v1_lvl`=1 for `t_vpulse` cycles. During both, `h1a`=1 and `h2`=0.
- R4: In dual mode, after register A is filled, `h1a`=0, `h1b`=1 and `h2`=0 for `t_abpulse` cycles. `h1a` then returns to 1 and register A is filled again before any shifting.
- R5: In single mode `h1b` stays 0 for the whole frame.
- R6: With binning, each register receives two row transfers before it is read. A readout group therefore consumes G = (dual?2:1)*(bin?2:1) rows.
- R7: The first D = min(`dump_rows`, ROWS) rows of a frame are each moved by one row transfer with `dump_gate`=1 for its full 2*`t_vpulse` cycles. No shifting follows these rows, and `dump_gate` is 0 at all other times.
- R8: Each readout group waits `t_hdelay` cycles and then shifts PIX pixel counts. Each count is one cycle with `h2`=1 and `h1a`=0 followed by one cycle with `h2`=0 and `h1a`=1. A pixel is delivered on each falling edge of `h2`. `h1b` follows `h1a` in dual mode, and `pix_idx` counts 0 to PIX-1.
- R9: After the dumped rows the frame runs ceil((ROWS-D)/G) groups, and the last group may be partial. `frame_done` is 1 for exactly one cycle after the last shift cycle. `line_idx` then holds the number of row transfers made, D + groups*G.
- R10: `retrace` is 1 exactly during the readout delay, row transfers, A-to-B hand-offs and horizontal delays, and 0 otherwise.
- R11: `frame_start` while busy is ignored. The mode inputs and `dump_rows` are latched at frame start, and changes during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle frame request |
| dual_en | input | 1 | 1 selects dual-register readout |
| bin_en | input | 1 | 1 selects two-to-one row binning |
| dump_rows | input | ROW_W | Rows to discard at top of frame |
| t_vpulse | input | TW | Vertical pulse width in cycles |
| t_vdelay | input | TW | Readout delay after photodiode transfer |
| t_hdelay | input | TW | Delay from last row transfer to shifting |
| t_abpulse | input | TW | A-to-B hand-off width |
| v1_lvl | output | 2 | Vertical phase one level code |
| v2 | output | 1 | Vertical phase two |
| h1a | output | 1 | Horizontal phase one, register A |
| h1b | output | 1 | Horizontal phase one, register B |
| h2 | output | 1 | Horizontal phase two, both registers |
| dump_gate | output | 1 | Fast dump gate |
| line_idx | output | ROW_W | Row transfers made this frame |
| pix_idx | output | PIX_W | Pixel count within current readout |
| retrace | output | 1 | Horizontal retrace window |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong mode latch or group counter shows up as a wrong number of `v2` pulses or `h2` falling edges per frame, or as `h1b` activity in single mode. These differences appear within the first readout group. A wrong phase timer lengthens or shortens the busy, retrace and `dump_gate` windows by a whole number of cycles, and the error is visible within the first pulse. A row counter that is off by one ends the frame a group early or late. That shows up in the busy length and in the final `line_idx`.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PDX, S_RDLY, S_V2HI, S_V2LO, S_ABX, S_HDLY, S_SHIFT, S_DONE
  } seq_state_e;

  localparam logic [1:0] LVL_LOW  = 2'd0;
  localparam logic [1:0] LVL_MID  = 2'd1;
  localparam logic [1:0] LVL_HIGH = 2'd2;
endpackage

// File: rtl/ccd_phase_timer.sv
module ccd_phase_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] dur,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= (dur == '0) ? '0 : dur - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ccd_line_tracker.sv
module ccd_line_tracker #(
  parameter int ROWS  = 496,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [ROW_W-1:0] dump_q,
  output logic [ROW_W-1:0] line_idx,
  output logic             dumping,
  output logic             last_moved,
  output logic             all_moved
);
  localparam logic [ROW_W-1:0] ROWS_L = ROW_W'(ROWS);
  logic [ROW_W-1:0] rows_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rows_q <= '0;
    else if (clr)  rows_q <= '0;
    else if (inc)  rows_q <= rows_q + 1'b1;
  end

  assign line_idx   = rows_q;
  assign dumping    = (rows_q < dump_q);
  assign last_moved = ((rows_q + 1'b1) >= ROWS_L);
  assign all_moved  = (rows_q >= ROWS_L);
endmodule

// File: rtl/ccd_pixel_shifter.sv
module ccd_pixel_shifter #(
  parameter int PIX   = 694,
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic             phase,
  output logic [PIX_W-1:0] pix_idx,
  output logic             last
);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      pix_idx <= '0;
    end else if (clr) begin
      phase   <= 1'b0;
      pix_idx <= '0;
    end else if (en) begin
      phase <= ~phase;
      if (phase) pix_idx <= last ? '0 : pix_idx + 1'b1;
    end
  end

  assign last = phase && (pix_idx == PIX_LAST);
endmodule

// File: rtl/ccd_phase_decode.sv
module ccd_phase_decode
  import ccd_seq_pkg::*;
(
  input  seq_state_e  state,
  input  logic        phase,
  input  logic        dual_q,
  input  logic        dumping,
  output logic [1:0]  v1_lvl,
  output logic        v2,
  output logic        h1a,
  output logic        h1b,
  output logic        h2,
  output logic        dump_gate,
  output logic        retrace,
  output logic        busy,
  output logic        frame_done
);
  logic shifting;
  assign shifting = (state == S_SHIFT);

  always_comb begin
    unique case (state)
      S_PDX:   v1_lvl = LVL_HIGH;
      S_V2HI:  v1_lvl = LVL_LOW;
      default: v1_lvl = LVL_MID;
    endcase
  end

  assign v2         = (state == S_V2HI);
  assign h2         = shifting && !phase;
  assign h1a        = !((state == S_ABX) || (shifting && !phase));
  assign h1b        = (state == S_ABX) || (shifting && phase && dual_q);
  assign dump_gate  = dumping && ((state == S_V2HI) || (state == S_V2LO));
  assign retrace    = (state == S_RDLY) || (state == S_V2HI) || (state == S_V2LO) ||
                      (state == S_ABX)  || (state == S_HDLY);
  assign busy       = (state != S_IDLE);
  assign frame_done = (state == S_DONE);
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int ROWS  = 496,
  parameter int PIX   = 694,
  parameter int TW    = 16,
  parameter int ROW_W = $clog2(ROWS + 4),
  parameter int PIX_W = (PIX > 1) ? $clog2(PIX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             dual_en,
  input  logic             bin_en,
  input  logic [ROW_W-1:0] dump_rows,
  input  logic [TW-1:0]    t_vpulse,
  input  logic [TW-1:0]    t_vdelay,
  input  logic [TW-1:0]    t_hdelay,
  input  logic [TW-1:0]    t_abpulse,
  output logic [1:0]       v1_lvl,
  output logic             v2,
  output logic             h1a,
  output logic             h1b,
  output logic             h2,
  output logic             dump_gate,
  output logic [ROW_W-1:0] line_idx,
  output logic [PIX_W-1:0] pix_idx,
  output logic             retrace,
  output logic             busy,
  output logic             frame_done
);
  seq_state_e state_q, nxt;
  logic dual_q, bin_q, reg_b_q, xfer_sec_q;
  logic [ROW_W-1:0] dump_q;
  logic expired, go, dumping, last_moved, all_moved, phase, pix_last;
  logic [TW-1:0] dur;
  logic accept;

  assign accept = (state_q == S_IDLE) && frame_start;

  // next-state selection
  always_comb begin
    nxt = state_q;
    unique case (state_q)
      S_IDLE:  if (frame_start) nxt = S_PDX;
      S_PDX:   if (expired) nxt = S_RDLY;
      S_RDLY:  if (expired) nxt = S_V2HI;
      S_V2HI:  if (expired) nxt = S_V2LO;
      S_V2LO:  if (expired) begin
                 if (dumping)                  nxt = last_moved ? S_DONE : S_V2HI;
                 else if (bin_q && !xfer_sec_q) nxt = S_V2HI;
                 else if (dual_q && !reg_b_q)   nxt = S_ABX;
                 else                           nxt = S_HDLY;
               end
      S_ABX:   if (expired) nxt = S_V2HI;
      S_HDLY:  if (expired) nxt = S_SHIFT;
      S_SHIFT: if (pix_last) nxt = all_moved ? S_DONE : S_V2HI;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign go = (nxt != state_q) || (state_q == S_V2LO && nxt == S_V2HI);

  always_comb begin
    unique case (nxt)
      S_PDX:          dur = t_vpulse;
      S_RDLY:         dur = t_vdelay;
      S_V2HI, S_V2LO: dur = t_vpulse;
      S_ABX:          dur = t_abpulse;
      S_HDLY:         dur = t_hdelay;
      default:        dur = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      dual_q     <= 1'b0;
      bin_q      <= 1'b0;
      dump_q     <= '0;
      reg_b_q    <= 1'b0;
      xfer_sec_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (accept) begin
        dual_q     <= dual_en;
        bin_q      <= bin_en;
        dump_q     <= dump_rows;
        reg_b_q    <= 1'b0;
        xfer_sec_q <= 1'b0;
      end else if (state_q == S_V2LO && expired && !dumping) begin
        if (bin_q && !xfer_sec_q) xfer_sec_q <= 1'b1;
        else begin
          xfer_sec_q <= 1'b0;
          if (dual_q && !reg_b_q) reg_b_q <= 1'b1;
        end
      end else if (state_q == S_SHIFT && pix_last) begin
        reg_b_q <= 1'b0;
      end
    end
  end

  ccd_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(go), .dur(dur), .expired(expired)
  );

  ccd_line_tracker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .inc(state_q == S_V2LO && expired),
    .dump_q(dump_q), .line_idx(line_idx), .dumping(dumping),
    .last_moved(last_moved), .all_moved(all_moved)
  );

  ccd_pixel_shifter #(.PIX(PIX), .PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != S_SHIFT && nxt == S_SHIFT),
    .en(state_q == S_SHIFT),
    .phase(phase), .pix_idx(pix_idx), .last(pix_last)
  );

  ccd_phase_decode u_dec (
    .state(state_q), .phase(phase), .dual_q(dual_q), .dumping(dumping),
    .v1_lvl(v1_lvl), .v2(v2), .h1a(h1a), .h1b(h1b), .h2(h2),
    .dump_gate(dump_gate), .retrace(retrace), .busy(busy),
    .frame_done(frame_done)
  );
endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       dual_q,
  input logic [1:0] v1_lvl,
  input logic       v2,
  input logic       h1a,
  input logic       h1b,
  input logic       h2,
  input logic       dump_gate,
  input logic       retrace,
  input logic       frame_done
);
  // R1
  lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1_lvl != 2'd3);

  // R3
  v2_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (v1_lvl == 2'd0 && h1a && !h2));

  // R4
  ab_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!h1a && !h2) |-> (h1b && retrace));

  // R5
  single_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dual_q && !retrace) |-> !h1b);

  // R7
  dump_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_gate |-> (retrace && v1_lvl != 2'd2));

  // R8
  shift_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2 |-> (!h1a && !h1b && !retrace));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dual_q));
endmodule

bind ccd_readout_seq ccd_readout_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dual_q(dual_q), .v1_lvl(v1_lvl),
  .v2(v2), .h1a(h1a), .h1b(h1b), .h2(h2), .dump_gate(dump_gate),
  .retrace(retrace), .frame_done(frame_done)
);

// File: tb/tb_ccd_readout_seq.sv
`timescale 1ns/1ps
module tb_ccd_readout_seq;
  localparam int ROWS  = 8;
  localparam int PIX   = 5;
  localparam int TW    = 8;
  localparam int ROW_W = $clog2(ROWS + 4);
  localparam int PIX_W = $clog2(PIX);
  localparam int TV = 2, TRD = 3, THD = 2, TAB = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, dual_en = 1'b0, bin_en = 1'b0;
  logic [ROW_W-1:0] dump_rows = '0;
  logic [1:0] v1_lvl;
  logic v2, h1a, h1b, h2, dump_gate, retrace, busy, frame_done;
  logic [ROW_W-1:0] line_idx;
  logic [PIX_W-1:0] pix_idx;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ccd_readout_seq #(.ROWS(ROWS), .PIX(PIX), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .dual_en(dual_en), .bin_en(bin_en), .dump_rows(dump_rows),
    .t_vpulse(TW'(TV)), .t_vdelay(TW'(TRD)), .t_hdelay(TW'(THD)),
    .t_abpulse(TW'(TAB)),
    .v1_lvl(v1_lvl), .v2(v2), .h1a(h1a), .h1b(h1b), .h2(h2),
    .dump_gate(dump_gate), .line_idx(line_idx), .pix_idx(pix_idx),
    .retrace(retrace), .busy(busy), .frame_done(frame_done)
  );

  // monitor counters, sampled at negedge
  logic mon = 1'b0;
  int c_busy, c_v1hi, c_v2rise, c_h2fall, c_h1b, c_dump, c_ret, c_done, c_ab, c_bad, pix_max;
  logic p_v2 = 1'b0, p_h2 = 1'b0;

  always @(negedge clk) begin
    if (mon) begin
      if (busy) c_busy++;
      if (v1_lvl == 2'd2) c_v1hi++;
      if (v2 && !p_v2) c_v2rise++;
      if (!h2 && p_h2) c_h2fall++;
      if (h1b) c_h1b++;
      if (dump_gate) c_dump++;
      if (retrace) c_ret++;
      if (frame_done) c_done++;
      if (h1b && !h1a && !h2) c_ab++;
      if ((v2 && (!h1a || h2)) || (h2 && h1a)) c_bad++;
      if (h2 && int'(pix_idx) > pix_max) pix_max = int'(pix_idx);
    end
    p_v2 = v2;
    p_h2 = h2;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit d, input bit b, input int dmp, input bit disturb);
    int deff, g, grp, ret, tot, nreg, bv, guard;
    deff = (dmp < ROWS) ? dmp : ROWS;
    nreg = d ? 2 : 1;
    bv   = b ? 2 : 1;
    g    = nreg * bv;
    grp  = (ROWS - deff + g - 1) / g;
    ret  = TRD + deff * 2 * TV + grp * (g * 2 * TV + (d ? TAB : 0) + THD);
    tot  = TV + ret + grp * 2 * PIX + 1;
    c_busy = 0; c_v1hi = 0; c_v2rise = 0; c_h2fall = 0; c_h1b = 0;
    c_dump = 0; c_ret = 0; c_done = 0; c_ab = 0; c_bad = 0; pix_max = -1;
    @(negedge clk);
    dual_en = d; bin_en = b; dump_rows = ROW_W'(dmp);
    frame_start = 1'b1; mon = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    guard = 0;
    while (busy && guard < 5000) begin
      if (disturb && guard == 20) begin
        frame_start = 1'b1; dual_en = ~d; bin_en = ~b; dump_rows = '0;
      end else if (disturb && guard == 21) frame_start = 1'b0;
      @(negedge clk);
      guard++;
    end
    mon = 1'b0;
    if (guard >= 5000) chk("R9", "watchdog", 1, 0);
    chk("R9",  "busy cycles", c_busy, tot);
    chk("R2",  "v1 high cycles", c_v1hi, TV);
    chk("R3",  "row transfers (v2 rises)", c_v2rise, deff + grp * g);
    chk("R6",  "row transfers per group", grp * g, c_v2rise - deff);
    chk("R8",  "pixels (h2 falls)", c_h2fall, grp * PIX);
    chk("R8",  "max pix_idx", pix_max, (grp > 0) ? PIX - 1 : -1);
    chk("R3",  "phase conflicts", c_bad, 0);
    chk(d ? "R4" : "R5", "h1b high cycles", c_h1b, d ? grp * (TAB + PIX) : 0);
    chk("R4",  "A-to-B cycles", c_ab, d ? grp * TAB : 0);
    chk("R7",  "dump gate cycles", c_dump, deff * 2 * TV);
    chk("R10", "retrace cycles", c_ret, ret);
    chk("R9",  "frame_done pulses", c_done, 1);
    chk("R9",  "final line_idx", int'(line_idx), deff + grp * g);
    if (disturb) chk("R11", "still idle after ignored start", int'(busy), 0);
    dual_en = 1'b0; bin_en = 1'b0; dump_rows = '0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R9 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle levels
    chk("R1", "v1_lvl", int'(v1_lvl), 1);
    chk("R1", "v2/h1b/h2", int'({v2, h1b, h2}), 0);
    chk("R1", "h1a", int'(h1a), 1);
    chk("R1", "busy/done/dump", int'({busy, frame_done, dump_gate}), 0);
    // R2 R3 R4 R5 R6 R7 R8 sweep over modes and dump counts
    for (int dmp = 0; dmp <= 3; dmp += 3)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 2; b++)
          run_frame(d[0], b[0], dmp, 1'b0);
    run_frame(1'b1, 1'b0, 1, 1'b0);
    run_frame(1'b0, 1'b0, ROWS, 1'b0);   // R7 every row dumped
    run_frame(1'b0, 1'b1, ROWS + 2, 1'b0);
    // R11 start and mode changes mid-frame ignored
    run_frame(1'b0, 1'b0, 0, 1'b1);
    run_frame(1'b1, 1'b1, 2, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule